// File: doc/BRIEF.md
# Inverting-Operand Arithmetic Logic Unit

This block is a purely combinational 32-bit arithmetic logic unit for a simple single-cycle processor datapath. It takes two operands and a 4-bit operation code, and it returns a 32-bit result together with a flag that is high when that result is zero. The datapath uses the flag to decide equality-based branches: it selects subtraction and tests whether the difference is zero.

The operation code has two parts. The high two bits are invert controls, one for each operand. The low two bits choose a core function: AND, OR, add, or set-less-than. Subtraction is an add with the second operand inverted and a carry-in of one. NOR is an AND with both operands inverted. Set-less-than reuses the subtraction path. Any code outside the six defined ones gives a result of zero.

Top module: `inv_alu`

## Requirements
- R1: Code 4'b0000 gives the bitwise AND of the two operands.
- R2: Code 4'b0001 gives the bitwise OR of the two operands.
- R3: Code 4'b0010 gives the sum of the two operands modulo 2^32. The carry out of bit 31 is discarded.
- R4: Code 4'b0110 gives the first operand minus the second, modulo 2^32. It is computed as first + inverted second + 1.
- R5: Code 4'b0111 gives 1 in bit 0 when the first operand is less than the second as signed two's-complement values, and 0 otherwise. Bits 31..1 are always zero. The result stays correct when the subtraction overflows.
- R6: Code 4'b1100 gives the bitwise NOR of the two operands.
- R7: The zero flag is high exactly when all 32 result bits are zero, for every code.
- R8: Every code other than 0000, 0001, 0010, 0110, 0111 and 1100 gives a result of zero, so the zero flag is high for those codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 4 | Bit 3 inverts opnd_a, bit 2 inverts opnd_b, bits 1:0 select the core function |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The block holds no state, so a wrong internal value appears at the ports in the same evaluation as the inputs that cause it. The faults that are hard to see involve the inversion and carry-in wiring. A missing carry-in makes subtraction off by one. Taking the sign of the difference without the overflow correction gives the wrong set-less-than answer only for operands of opposite sign with large magnitude. A bad decode of the unused codes leaks AND or OR values onto the result. The stimulus therefore includes overflow pairs, equal operands, and every one of the sixteen codes.

// File: rtl/inv_alu.sv
module inv_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  logic             inv_a, inv_b;
  logic [1:0]       core;
  logic [WIDTH-1:0] x, y, sum;
  logic             ovf, less, legal;

  assign inv_a = op_code[3];
  assign inv_b = op_code[2];
  assign core  = op_code[1:0];

  assign x   = inv_a ? ~opnd_a : opnd_a;
  assign y   = inv_b ? ~opnd_b : opnd_b;
  assign sum = x + y + {{(WIDTH-1){1'b0}}, inv_b};

  assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  assign less = sum[MSB] ^ ovf;

  always_comb begin
    case (op_code)
      4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100: legal = 1'b1;
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    result = '0;
    if (legal) begin
      case (core)
        2'b00: result = x & y;
        2'b01: result = x | y;
        2'b10: result = sum;
        2'b11: result = {{(WIDTH-1){1'b0}}, less};
      endcase
    end
  end

  assign zero = ~|result;

  always_comb begin
    // R3
    add_path_chk: assert (op_code != 4'b0010 || result == opnd_a + opnd_b);
    // R4
    sub_path_chk: assert (op_code != 4'b0110 || result == opnd_a - opnd_b);
    // R5
    slt_path_chk: assert (op_code != 4'b0111 ||
                          result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))});
    // R6
    nor_path_chk: assert (op_code != 4'b1100 || result == ~(opnd_a | opnd_b));
    // R8
    unused_code_chk: assert (legal || (result == '0 && zero));
  end
endmodule

// File: tb/inv_alu_tb.sv
module inv_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  op = '0;
  logic [31:0] res;
  logic        zf;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic        z;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  inv_alu u_dut (.opnd_a(a), .opnd_b(b), .op_code(op), .result(res), .zero(zf));

  function automatic logic [31:0] model(input logic [31:0] p, input logic [31:0] s, input logic [3:0] c);
    case (c)
      4'b0000: return p & s;
      4'b0001: return p | s;
      4'b0010: return p + s;
      4'b0110: return p - s;
      4'b0111: return ($signed(p) < $signed(s)) ? 32'd1 : 32'd0;
      4'b1100: return ~(p | s);
      default: return 32'd0;
    endcase
  endfunction

  task automatic drive(input logic [31:0] p, input logic [31:0] s, input logic [3:0] c, input string tag);
    exp_t e;
    @(posedge clk);
    a = p; b = s; op = c;
    e.r = model(p, s, c);
    e.z = (e.r == 32'd0);
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (res !== e.r || zf !== e.z) begin
          fails++;
          $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b", e.tag, res, zf, e.r, e.z);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(posedge clk);
    rst = 1'b0;
    drive(32'h0, 32'h0, 4'b0000, "R7 reset idle");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000, "R1 and");
    drive(32'hAAAA_0000, 32'h5555_0000, 4'b0000, "R1 and disjoint R7");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001, "R2 or");
    drive(32'h0, 32'h0, 4'b0001, "R2 or zero R7");
    drive(32'd100, 32'd23, 4'b0010, "R3 add");
    drive(32'hFFFF_FFFF, 32'd1, 4'b0010, "R3 add wrap R7");
    drive(32'd100, 32'd23, 4'b0110, "R4 sub");
    drive(32'd5, 32'd9, 4'b0110, "R4 sub negative");
    drive(32'h1234_5678, 32'h1234_5678, 4'b0110, "R4 sub equal R7");
    drive(32'hFFFF_FFFE, 32'd3, 4'b0111, "R5 slt neg<pos");
    drive(32'd3, 32'hFFFF_FFFE, 4'b0111, "R5 slt pos>neg");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111, "R5 slt overflow min<max");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111, "R5 slt overflow max>min");
    drive(32'd7, 32'd7, 4'b0111, "R5 slt equal");
    drive(32'hF0F0_0000, 32'h0F0F_0000, 4'b1100, "R6 nor");
    drive(32'hFFFF_0000, 32'h0000_FFFF, 4'b1100, "R6 nor all ones R7");
    for (int c = 0; c < 16; c++)
      drive(32'hDEAD_BEEF, 32'h1357_9BDF, 4'(c), "R8 code sweep");
    for (int i = 0; i < 40; i++)
      drive($urandom, $urandom, 4'($urandom_range(0, 15)), "R7 mixed");
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule